// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of a three-phase dual-slope converter. It holds the phase state machine and the phase counter, and it latches the result. An internal count enable runs at one quarter of the input clock, and every phase length is measured in those counts. The machine runs a zeroing phase first, with the offset-cancel loop closed and the inputs open. It then integrates the input for a fixed number of counts. Last, it de-integrates with a reference of the opposite sign until the comparator reports that the integrator has crossed zero.

The elapsed de-integrate count is the magnitude of the reading, and it equals INT_COUNTS × Vin / Vref. The comparator's view at the end of integration gives the sign. The zeroing phase absorbs the time the de-integrate phase did not use, so every conversion has the same length. The analog switches are driven straight from the phase decode. The comparator input passes through a two-flop synchronizer before the machine uses it.

States and transitions. `PH_ZERO` moves to `PH_INTEG` when its variable length expires (transition ZERO_DONE). `PH_INTEG` moves to `PH_DEINT` after INT_COUNTS counts (transition INTEG_DONE), and the sign is latched on that step. `PH_DEINT` moves back to `PH_ZERO` on a zero crossing (transition CROSSED) or on reaching DEINT_MAX (transition OVERRANGE). A synchronous reset forces `PH_ZERO` from any state (transition RESET).

Top module: `adc_seq`

## Requirements
- R1: A synchronous reset puts the machine in the zeroing phase, clears the counters and all result outputs, and makes the first zeroing phase last CYCLE_COUNTS − INT_COUNTS counts.
- R2: Phases always run zeroing, then integrate, then de-integrate, then zeroing again. Exactly one of `az_en`, `in_en` and `ref_en` is high in every cycle.
- R3: One count is PRESCALE input clocks, so each phase lasts a whole multiple of PRESCALE clocks.
- R4: The integrate phase (`in_en` high) lasts exactly INT_COUNTS counts.
- R5: The sign is taken from the synchronized comparator on the last integrate count. `res_neg` is 1 when the comparator was low (integrator below zero). During de-integrate, `ref_neg` is 1 exactly when the latched sign is positive, and it does not change within the phase.
- R6: De-integrate ends at the first count boundary where the synchronized comparator differs from its state at the end of integrate. A comparator change made more than two clocks before a boundary is acted on at that boundary. The reading is the number of whole counts that passed before that boundary, so the phase lasts reading + 1 counts.
- R7: If no crossing is seen by the boundary where the count reaches DEINT_MAX, de-integrate ends there. In that case `res_ovr` is 1, the reading is DEINT_MAX and the phase lasts DEINT_MAX + 1 counts. A crossing seen at that same boundary is a normal result with `res_ovr` 0.
- R8: Every zeroing phase after a conversion lasts CYCLE_COUNTS − INT_COUNTS − reading counts.
- R9: `res_neg`, `res_count` and `res_ovr` are updated together at the end of de-integrate. `res_valid` is high for exactly one clock, on the first clock of the following zeroing phase, and the results hold until the next update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | External clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_in | input | 1 | Comparator output, 1 when the integrator is above zero (asynchronous) |
| az_en | output | 1 | Closes the zeroing and offset-cancel loop |
| in_en | output | 1 | Connects the differential input to the integrator |
| ref_en | output | 1 | Connects the reference capacitor to the integrator |
| ref_neg | output | 1 | Reference sign during de-integrate, 1 for negative |
| res_neg | output | 1 | Latched sign of the last conversion, 1 for negative |
| res_count | output | RES_W | Latched de-integrate count, 0 to DEINT_MAX |
| res_ovr | output | 1 | Latched overrange flag |
| res_valid | output | 1 | One-clock strobe marking new results |

## Verification
The bench shrinks the counts to a small configuration (integrate 10, de-integrate limit 20, cycle 40). It scripts the comparator so that it flips after every crossing delay from 0 to two counts past the limit, once for a positive input and once for a negative one. The zero-delay runs show that the sign is right for an input below one LSB. The delays at and beyond the limit separate a last-count crossing from an overrange. Each run measures every phase length in clocks, so it checks both the de-integrate reading and the variable zeroing length that follows it. A reset applied during de-integrate shows that the machine restarts with the initial zeroing length and with cleared results.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        PH_ZERO  = 2'd0,
        PH_INTEG = 2'd1,
        PH_DEINT = 2'd2
    } phase_t;

endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV == 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_div
            logic [PW-1:0] pcnt;
            assign tick = (pcnt == PW'(DIV - 1));
            always_ff @(posedge clk) begin
                if (rst || tick) begin
                    pcnt <= '0;
                end else begin
                    pcnt <= pcnt + 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/adc_sync2.sv
module adc_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg #(
    parameter int RES_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             neg_in,
    input  logic [RES_W-1:0] count_in,
    input  logic             ovr_in,
    output logic             res_neg,
    output logic [RES_W-1:0] res_count,
    output logic             res_ovr,
    output logic             res_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            res_neg   <= 1'b0;
            res_count <= '0;
            res_ovr   <= 1'b0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= load;
            if (load) begin
                res_neg   <= neg_in;
                res_count <= count_in;
                res_ovr   <= ovr_in;
            end
        end
    end
endmodule

// File: rtl/adc_seq.sv
module adc_seq
    import adc_seq_pkg::*;
#(
    parameter int PRESCALE     = 4,
    parameter int INT_COUNTS   = 1000,
    parameter int DEINT_MAX    = 2000,
    parameter int CYCLE_COUNTS = 4000,
    parameter int RES_W        = $clog2(DEINT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmp_in,
    output logic             az_en,
    output logic             in_en,
    output logic             ref_en,
    output logic             ref_neg,
    output logic             res_neg,
    output logic [RES_W-1:0] res_count,
    output logic             res_ovr,
    output logic             res_valid
);
    localparam int CNT_W   = $clog2(CYCLE_COUNTS + 1);
    localparam int AZ_INIT = CYCLE_COUNTS - INT_COUNTS;

    phase_t           phase;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] az_len;
    logic             pol_neg;
    logic             tick;
    logic             cmp_s;

    logic             zero_done;
    logic             integ_done;
    logic             crossed;
    logic             at_limit;
    logic             finish;
    logic [CNT_W-1:0] az_next;

    adc_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    adc_sync2 #(.STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (cmp_in),
        .q   (cmp_s)
    );

    // Transition conditions, evaluated on a count boundary.
    always_comb begin
        zero_done  = (cnt == az_len - 1'b1);
        integ_done = (cnt == CNT_W'(INT_COUNTS - 1));
        crossed    = (cmp_s == pol_neg);
        at_limit   = (cnt == CNT_W'(DEINT_MAX));
        finish     = tick && (phase == PH_DEINT) && (crossed || at_limit);
        az_next    = CNT_W'(AZ_INIT) - cnt;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_ZERO;
            cnt     <= '0;
            az_len  <= CNT_W'(AZ_INIT);
            pol_neg <= 1'b0;
        end else if (tick) begin
            unique case (phase)
                PH_ZERO: begin
                    if (zero_done) begin
                        phase <= PH_INTEG;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_INTEG: begin
                    if (integ_done) begin
                        phase   <= PH_DEINT;
                        cnt     <= '0;
                        pol_neg <= ~cmp_s;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_DEINT: begin
                    if (crossed || at_limit) begin
                        phase  <= PH_ZERO;
                        cnt    <= '0;
                        az_len <= az_next;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    phase <= PH_ZERO;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // Switch outputs decoded from the phase.
    always_comb begin
        az_en   = 1'b0;
        in_en   = 1'b0;
        ref_en  = 1'b0;
        ref_neg = 1'b0;
        unique case (phase)
            PH_ZERO:  az_en = 1'b1;
            PH_INTEG: in_en = 1'b1;
            PH_DEINT: begin
                ref_en  = 1'b1;
                ref_neg = ~pol_neg;
            end
            default:  az_en = 1'b1;
        endcase
    end

    adc_result_reg #(.RES_W(RES_W)) u_res (
        .clk       (clk),
        .rst       (rst),
        .load      (finish),
        .neg_in    (pol_neg),
        .count_in  (cnt[RES_W-1:0]),
        .ovr_in    (~crossed),
        .res_neg   (res_neg),
        .res_count (res_count),
        .res_ovr   (res_ovr),
        .res_valid (res_valid)
    );
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker #(
    parameter int DEINT_MAX = 2000,
    parameter int RES_W     = 11
) (
    input logic             clk,
    input logic             rst,
    input logic             az_en,
    input logic             in_en,
    input logic             ref_en,
    input logic             ref_neg,
    input logic             res_neg,
    input logic [RES_W-1:0] res_count,
    input logic             res_ovr,
    input logic             res_valid
);
    // R2: exactly one phase enable
    a_r2_one_phase: assert property (@(posedge clk) disable iff (rst)
        $onehot({az_en, in_en, ref_en}));

    // R2: integrate only follows zeroing
    a_r2_integ_after_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(in_en) |-> $past(az_en));

    // R2: de-integrate only follows integrate
    a_r2_deint_after_integ: assert property (@(posedge clk) disable iff (rst)
        $rose(ref_en) |-> $past(in_en));

    // R2: zeroing follows de-integrate or a reset
    a_r2_zero_after_deint: assert property (@(posedge clk) disable iff (rst)
        $rose(az_en) |-> ($past(ref_en) || $past(rst)));

    // R5: reference sign is stable through de-integrate
    a_r5_ref_sign_stable: assert property (@(posedge clk) disable iff (rst)
        (ref_en && $past(ref_en)) |-> $stable(ref_neg));

    // R7: reading never exceeds the limit, overrange reports the limit
    a_r7_limit: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> ((res_count <= RES_W'(DEINT_MAX)) &&
                       (!res_ovr || res_count == RES_W'(DEINT_MAX))));

    // R9: strobe lasts one clock
    a_r9_pulse: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    // R9: strobe appears with the first zeroing clock
    a_r9_with_zero: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (az_en && $past(ref_en)));

    // R9: results hold between strobes
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (!res_valid && !$past(rst)) |->
            ($stable(res_count) && $stable(res_neg) && $stable(res_ovr)));
endmodule

bind adc_seq adc_seq_checker #(
    .DEINT_MAX (DEINT_MAX),
    .RES_W     (RES_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .az_en     (az_en),
    .in_en     (in_en),
    .ref_en    (ref_en),
    .ref_neg   (ref_neg),
    .res_neg   (res_neg),
    .res_count (res_count),
    .res_ovr   (res_ovr),
    .res_valid (res_valid)
);

// File: tb/adc_seq_test.sv
module adc_seq_test;
    localparam int PS   = 4;
    localparam int NI   = 10;
    localparam int NMAX = 20;
    localparam int NC   = 40;
    localparam int RW   = $clog2(NMAX + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmp = 1'b0;
    logic          az_en, in_en, ref_en, ref_neg;
    logic          res_neg, res_ovr, res_valid;
    logic [RW-1:0] res_count;

    int errs   = 0;
    int checks = 0;

    always #5 clk = ~clk;

    adc_seq #(
        .PRESCALE     (PS),
        .INT_COUNTS   (NI),
        .DEINT_MAX    (NMAX),
        .CYCLE_COUNTS (NC)
    ) uut (
        .clk       (clk),
        .rst       (rst),
        .cmp_in    (cmp),
        .az_en     (az_en),
        .in_en     (in_en),
        .ref_en    (ref_en),
        .ref_neg   (ref_neg),
        .res_neg   (res_neg),
        .res_count (res_count),
        .res_ovr   (res_ovr),
        .res_valid (res_valid)
    );

    task automatic expect_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count negedges while az_en stays high, starting at the current one.
    task automatic time_zero(output int n);
        n = 0;
        while (az_en) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        #2000000;
        errs++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int n;
        int prev_rd;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        expect_eq("R1 az_en", int'(az_en), 1);
        expect_eq("R1 in_en", int'(in_en), 0);
        expect_eq("R1 ref_en", int'(ref_en), 0);
        expect_eq("R1 res_valid", int'(res_valid), 0);
        expect_eq("R1 res_count", int'(res_count), 0);
        expect_eq("R1 res_ovr", int'(res_ovr), 0);
        expect_eq("R1 res_neg", int'(res_neg), 0);
        rst = 1'b0;

        // R1/R8: first zeroing length
        time_zero(n);
        expect_eq("R1 first zeroing clocks", n, PS * (NC - NI));
        prev_rd = -1;

        for (int k = 0; k <= NMAX + 2; k++) begin
            for (int s = 0; s < 2; s++) begin
                int exp_rd;
                int i;
                if (prev_rd >= 0) begin
                    time_zero(n);
                    // one zeroing clock already consumed by the strobe check
                    expect_eq("R8 zeroing clocks", n + 1, PS * (NC - NI - prev_rd));
                end
                expect_eq("R2 integrate follows zeroing", int'(in_en), 1);
                cmp = (s == 0);
                n = 0;
                while (in_en) begin
                    n++;
                    @(negedge clk);
                end
                expect_eq("R4 integrate clocks (R3 prescale)", n, PS * NI);
                expect_eq("R2 de-integrate follows integrate", int'(ref_en), 1);
                expect_eq("R5 reference sign", int'(ref_neg), (s == 0) ? 1 : 0);

                i = 0;
                while (ref_en) begin
                    if (i == PS * k) cmp = (s != 0);
                    i++;
                    @(negedge clk);
                end
                exp_rd = (k > NMAX) ? NMAX : k;
                expect_eq("R6 de-integrate clocks", i, PS * (exp_rd + 1));
                expect_eq("R9 strobe high", int'(res_valid), 1);
                expect_eq("R2 zeroing follows de-integrate", int'(az_en), 1);
                expect_eq("R6 reading", int'(res_count), exp_rd);
                expect_eq("R7 overrange flag", int'(res_ovr), (k > NMAX) ? 1 : 0);
                expect_eq("R5 latched sign", int'(res_neg), s);
                @(negedge clk);
                expect_eq("R9 strobe one clock", int'(res_valid), 0);
                expect_eq("R9 reading held", int'(res_count), exp_rd);
                prev_rd = exp_rd;
            end
        end

        // R1: reset in the middle of de-integrate
        while (!ref_en) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        expect_eq("R1 reset to zeroing", int'(az_en), 1);
        expect_eq("R1 reset drops reference", int'(ref_en), 0);
        expect_eq("R1 reset clears reading", int'(res_count), 0);
        expect_eq("R1 reset clears sign", int'(res_neg), 0);
        expect_eq("R1 reset clears strobe", int'(res_valid), 0);
        time_zero(n);
        expect_eq("R1 zeroing after reset", n, PS * (NC - NI));

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule